// File: doc/BRIEF.md
# Ternary Content-Addressable Memory with Sequential Scan

This block holds a small table of keys, each marked either empty or occupied. A caller issues one command at a time: search, search-next, insert, delete by key, delete by index, or flush. Searches and deletes by key compare a key with each occupied entry under a per-bit care mask: a mask bit of 1 makes that bit count and a mask bit of 0 makes it a don't-care. The lowest matching index is reported.

Keyed commands work through a scan engine that looks at one entry per clock. An insert scans for the lowest empty slot. Search-next resumes just after the entry that the last successful search or search-next returned, so repeated keys can be listed one by one. Deletes by index, flushes and unused opcodes finish in the cycle after they are accepted. Each command ends with a one-cycle `done` pulse. `hit`, `match_idx` and `full` belong to that pulse and hold their values until the next command finishes.

Top module: `tcam_scan`

## Requirements
- R1: After reset every entry is empty, the search-next resume point is index 0, and busy, done, hit, full and match_idx are all 0.
- R2: Search (opcode 0) reports the lowest occupied index i, scanning from 0, for which ((stored[i] XOR cmd_key) AND cmd_care) is zero. It reports this with done=1, hit=1 and match_idx=i.
- R3: Any command that finds nothing reports hit=0 and match_idx=0 with its done pulse.
- R4: A command is accepted on a rising edge where cmd_valid=1 and busy=0. A scan that starts at index s and ends at index k (or, with no match, at N-1) raises done at edge acceptance+(k-s+1). Busy is high from the edge after acceptance until done rises. Commands offered while busy is high are ignored.
- R5: Insert (opcode 2) writes cmd_key into the lowest empty entry, marks that entry occupied, and reports hit=1 with its index. Duplicate keys are allowed.
- R6: An insert into a table with no empty entry scans all N entries, then reports full=1 for exactly one cycle together with done=1 and hit=0. It changes no entry.
- R7: Delete by key (opcode 3) empties the lowest occupied entry that matches under the care mask and reports that index with hit=1. On a miss it changes nothing.
- R8: Delete by index (opcode 4) finishes in one cycle (done in the cycle after acceptance). It empties entry cmd_index and reports hit=1 with that index if the entry was occupied; otherwise it reports hit=0.
- R9: Flush (opcode 5) finishes in one cycle, empties every entry, resets the resume point to 0, and reports hit=0.
- R10: Search-next (opcode 1) scans from the resume point. A hit at index i from search or search-next sets the resume point to i+1. A miss from either of them sets it to N. With the resume point at N, search-next misses in one cycle.
- R11: Opcodes 6 and 7 finish in one cycle with hit=0 and change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 3 | Opcode: 0 search, 1 search-next, 2 insert, 3 delete by key, 4 delete by index, 5 flush |
| cmd_key | input | KEY_W | Key to compare or to store |
| cmd_care | input | KEY_W | Per-bit care mask; 1 = bit is compared |
| cmd_index | input | IDX_W | Entry number for delete by index |
| busy | output | 1 | Scan in progress, commands ignored |
| done | output | 1 | One-cycle pulse when a command finishes |
| hit | output | 1 | Command found or used an entry |
| match_idx | output | IDX_W | Index that was found, written or emptied; 0 on a miss |
| full | output | 1 | One-cycle pulse on a failed insert |

## Verification
On every cycle the assertions check the following. Done and busy never overlap. Busy falls only with a done pulse. A full pulse lasts one cycle and always comes with a done miss. Every miss reports index 0. Flush and delete by index finish in the cycle after acceptance. Which entry is chosen depends on the stored contents, so only the bench scenarios can show it. These scenarios cover duplicate keys walked by search-next, masked matches, a full table, and lowest-slot reuse after deletes. The same holds for the exact scan latency and for a command offered during a scan being ignored.

// File: rtl/tcam_scan.sv
module tcam_scan #(
  parameter int ENTRIES = 8,
  parameter int KEY_W = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [KEY_W-1:0] cmd_key,
  input  logic [KEY_W-1:0] cmd_care,
  input  logic [IDX_W-1:0] cmd_index,
  output logic             busy,
  output logic             done,
  output logic             hit,
  output logic [IDX_W-1:0] match_idx,
  output logic             full
);
  localparam logic [2:0] OP_SRCH = 3'd0, OP_NEXT = 3'd1, OP_INS = 3'd2,
                         OP_DKEY = 3'd3, OP_DIDX = 3'd4, OP_FLUSH = 3'd5;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);
  localparam logic [IDX_W-1:0] STEP = IDX_W'(1);
  localparam logic [IDX_W:0]   ENDP = (IDX_W + 1)'(ENTRIES);

  logic [KEY_W-1:0] store [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic             scan_q, done_q, hit_q, full_q;
  logic [2:0]       op_q;
  logic [KEY_W-1:0] key_q, care_q;
  logic [IDX_W-1:0] ptr_q, idx_q;
  logic [IDX_W:0]   resume_q;

  wire ent_match = valid_q[ptr_q] && (((store[ptr_q] ^ key_q) & care_q) == '0);
  wire found     = (op_q == OP_INS) ? !valid_q[ptr_q] : ent_match;
  wire at_last   = (ptr_q == LAST);
  wire srch_q    = (op_q == OP_SRCH) || (op_q == OP_NEXT);
  wire idx_ok    = ({1'b0, cmd_index} < ENDP);
  wire didx_hit  = idx_ok && valid_q[cmd_index];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= '0;
      scan_q   <= 1'b0;
      done_q   <= 1'b0;
      hit_q    <= 1'b0;
      full_q   <= 1'b0;
      idx_q    <= '0;
      ptr_q    <= '0;
      op_q     <= OP_SRCH;
      key_q    <= '0;
      care_q   <= '0;
      resume_q <= '0;
    end else begin
      done_q <= 1'b0;
      full_q <= 1'b0;
      if (scan_q) begin
        if (found) begin
          scan_q <= 1'b0;
          done_q <= 1'b1;
          hit_q  <= 1'b1;
          idx_q  <= ptr_q;
          if (op_q == OP_INS)  valid_q[ptr_q] <= 1'b1;
          if (op_q == OP_DKEY) valid_q[ptr_q] <= 1'b0;
          if (srch_q) resume_q <= {1'b0, ptr_q} + (IDX_W + 1)'(1);
        end else if (at_last) begin
          scan_q <= 1'b0;
          done_q <= 1'b1;
          hit_q  <= 1'b0;
          idx_q  <= '0;
          full_q <= (op_q == OP_INS);
          if (srch_q) resume_q <= ENDP;
        end else begin
          ptr_q <= ptr_q + STEP;
        end
      end else if (cmd_valid) begin
        op_q   <= cmd_op;
        key_q  <= cmd_key;
        care_q <= cmd_care;
        case (cmd_op)
          OP_SRCH, OP_INS, OP_DKEY: begin
            scan_q <= 1'b1;
            ptr_q  <= '0;
          end
          OP_NEXT: begin
            if (resume_q >= ENDP) begin
              done_q <= 1'b1;
              hit_q  <= 1'b0;
              idx_q  <= '0;
            end else begin
              scan_q <= 1'b1;
              ptr_q  <= resume_q[IDX_W-1:0];
            end
          end
          OP_DIDX: begin
            done_q <= 1'b1;
            hit_q  <= didx_hit;
            idx_q  <= didx_hit ? cmd_index : '0;
            if (didx_hit) valid_q[cmd_index] <= 1'b0;
          end
          OP_FLUSH: begin
            valid_q  <= '0;
            resume_q <= '0;
            done_q   <= 1'b1;
            hit_q    <= 1'b0;
            idx_q    <= '0;
          end
          default: begin
            done_q <= 1'b1;
            hit_q  <= 1'b0;
            idx_q  <= '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (scan_q && found && op_q == OP_INS) store[ptr_q] <= key_q;
  end

  assign busy      = scan_q;
  assign done      = done_q;
  assign hit       = hit_q;
  assign match_idx = idx_q;
  assign full      = full_q;
endmodule

module tcam_scan_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic             busy,
  input logic             done,
  input logic             hit,
  input logic [IDX_W-1:0] match_idx,
  input logic             full
);
  // R4
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
  // R4
  busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R6
  full_with_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (done && !hit));
  // R6
  full_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> !full);
  // R3
  miss_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hit) |-> (match_idx == '0));
  // R9
  flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 3'd5) |=> (done && !hit && !busy));
  // R8
  didx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 3'd4) |=> (done && !busy));
endmodule

bind tcam_scan tcam_scan_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .done(done), .hit(hit), .match_idx(match_idx), .full(full)
);

// File: tb/sim_tcam_scan.sv
`timescale 1ns/1ps
module sim_tcam_scan;
  localparam int N = 8;
  localparam int KW = 32;
  localparam int IW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [KW-1:0] cmd_key = '0, cmd_care = '0;
  logic [IW-1:0] cmd_index = '0;
  logic busy, done, hit, full;
  logic [IW-1:0] match_idx;

  int checks = 0, errors = 0;
  bit   mval [N];
  logic [KW-1:0] mkey [N];
  int   mres = 0;

  always #2.5 clk = ~clk;

  tcam_scan #(.ENTRIES(N), .KEY_W(KW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_key(cmd_key), .cmd_care(cmd_care), .cmd_index(cmd_index),
    .busy(busy), .done(done), .hit(hit), .match_idx(match_idx), .full(full)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int mfind(input int start, input logic [KW-1:0] k,
                               input logic [KW-1:0] c, input bit empty);
    for (int i = start; i < N; i++)
      if (empty ? !mval[i] : (mval[i] && (((mkey[i] ^ k) & c) == '0))) return i;
    return -1;
  endfunction

  task automatic run(input logic [2:0] op, input logic [KW-1:0] key,
                     input logic [KW-1:0] care, input int idx,
                     input string tag, input bit poke = 1'b0);
    int s, k, L, ei;
    bit eh, ef;
    s = 0; L = 0; eh = 0; ei = 0; ef = 0;
    case (op)
      3'd0, 3'd1, 3'd2, 3'd3: begin
        if (op == 3'd1 && mres >= N) L = 0;
        else begin
          s = (op == 3'd1) ? mres : 0;
          k = mfind(s, key, care, op == 3'd2);
          if (k >= 0) begin
            L = k - s + 1; eh = 1; ei = k;
            if (op <= 3'd1) mres = k + 1;
            if (op == 3'd2) begin mval[k] = 1; mkey[k] = key; end
            if (op == 3'd3) mval[k] = 0;
          end else begin
            L = N - s; ef = (op == 3'd2);
            if (op <= 3'd1) mres = N;
          end
        end
      end
      3'd4: if (idx < N && mval[idx]) begin eh = 1; ei = idx; mval[idx] = 0; end
      3'd5: begin
        for (int i = 0; i < N; i++) mval[i] = 0;
        mres = 0;
      end
      default: ;
    endcase
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_key = key; cmd_care = care;
    cmd_index = IW'(idx);
    @(posedge clk);
    for (int n = 1; n <= L + 1; n++) begin
      @(negedge clk);
      if (n == 1) begin
        if (poke) begin cmd_op = 3'd5; cmd_key = '0; end
        else cmd_valid = 1'b0;
      end
      if (n == 2) cmd_valid = 1'b0;
      chk(busy == (n <= L), {tag, "/R4"}, "busy", int'(busy), int'(n <= L));
      chk(done == (n == L + 1), {tag, "/R4"}, "done", int'(done), int'(n == L + 1));
      if (n == L + 1) begin
        chk(hit == eh, tag, "hit", int'(hit), int'(eh));
        chk(int'(match_idx) == ei, eh ? tag : {tag, "/R3"}, "match_idx",
            int'(match_idx), ei);
        chk(full == ef, {tag, "/R6"}, "full", int'(full), int'(ef));
      end
    end
    cmd_valid = 1'b0;
  endtask

  localparam logic [KW-1:0] KA = 32'hDEAD_0001, KB = 32'hBEEF_0002,
                            KC = 32'h1234_5678, ALL = 32'hFFFF_FFFF;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mval[i] = 0; mkey[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    chk(!busy, "R1", "busy", int'(busy), 0);
    chk(!done, "R1", "done", int'(done), 0);
    chk(!hit,  "R1", "hit",  int'(hit), 0);
    chk(!full, "R1", "full", int'(full), 0);
    chk(match_idx == '0, "R1", "match_idx", int'(match_idx), 0);
    run(3'd0, KA, ALL, 0, "R1_empty_search");
    run(3'd1, KA, ALL, 0, "R10_exhausted");
    // R5 insert lowest empty, duplicates allowed
    run(3'd2, KA, ALL, 0, "R5");
    run(3'd2, KB, ALL, 0, "R5");
    run(3'd2, KA, ALL, 0, "R5_dup");
    // R2 and R10 walk duplicates
    run(3'd0, KA, ALL, 0, "R2");
    run(3'd1, KA, ALL, 0, "R10");
    run(3'd1, KA, ALL, 0, "R10_tail_miss");
    run(3'd1, KA, ALL, 0, "R10_exhausted");
    // R2 masked matching
    run(3'd0, 32'h0000_0002, 32'h0000_FFFF, 0, "R2_mask");
    run(3'd0, 32'h0, 32'h0, 0, "R2_dontcare");
    run(3'd0, 32'hDEAD_0000, 32'hFFFF_0000, 0, "R2_mask_hi");
    // R8 delete by index
    run(3'd4, '0, '0, 0, "R8");
    run(3'd4, '0, '0, 0, "R8_empty");
    run(3'd0, KA, ALL, 0, "R8_after");
    // R4 command during scan ignored (flush poked while busy)
    run(3'd2, KC, ALL, 0, "R5_reuse", 1'b1);
    run(3'd0, KB, ALL, 0, "R4_ignored", 1'b1);
    run(3'd0, KC, ALL, 0, "R4_ignored");
    // R6 fill then overflow
    for (int i = 0; i < 5; i++) run(3'd2, KC, ALL, 0, "R5_fill");
    run(3'd2, KA, ALL, 0, "R6");
    run(3'd0, KA, ALL, 0, "R6_unchanged");
    // R7 delete by key
    run(3'd3, KC, ALL, 0, "R7");
    run(3'd3, 32'h5555_5555, ALL, 0, "R7_miss");
    run(3'd2, KB, ALL, 0, "R5_refill");
    // R10 walk to last entry then exhausted
    run(3'd0, KC, ALL, 0, "R2_c");
    for (int i = 0; i < 5; i++) run(3'd1, KC, ALL, 0, "R10_walk");
    // R11 unused opcodes
    run(3'd6, KA, ALL, 0, "R11");
    run(3'd7, KB, ALL, 0, "R11");
    run(3'd0, KB, ALL, 0, "R11_noeffect");
    // R9 flush
    run(3'd5, '0, '0, 0, "R9");
    run(3'd1, KA, '0, 0, "R9_resume");
    run(3'd0, KB, ALL, 0, "R9_empty");
    run(3'd4, '0, '0, 7, "R8_empty_last");
    run(3'd2, KB, ALL, 0, "R5_after_flush");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule